// File: doc/BRIEF.md
# Trace Queue with Overflow Recovery

This block buffers trace messages on their way from two producers to a single drain port. One producer delivers watchpoint messages and the other delivers data trace messages. Each message carries a payload word and a bit length. The producers cannot be stalled, so every arrival is either stored or dropped. The consumer takes stored messages in arrival order through a valid/ready handshake.

An arrival that does not fit in the queue starts an overflow episode. During the episode the queue accepts nothing and only drains. The block records which kinds of message it had to throw away. When the queue is empty again, it writes one error message that reports those kinds. Normal admission resumes on the following cycle.

Top module: `trq_queue`

## Requirements
- R1: After reset, `out_valid` is low and no message is queued.
- R2: Stored messages leave on the drain port in the order they were stored, with payload and length unchanged. A message leaves when `out_valid` and `out_ready` are both high on a clock edge.
- R3: When both producers present a message in the same cycle and both fit, the watchpoint message is stored ahead of the data trace message.
- R4: An arrival that finds no free entry is discarded and puts the block into overflow. Free space is counted before any pop in the same cycle.
- R5: While in overflow, every arrival from either producer is discarded until the queue has completely emptied.
- R6: In the first cycle that the queue is empty during overflow, one error message is stored and overflow ends. Its payload has the error type in bits [5:0], default 6'h08, and the error code in bits [10:6]. All other payload bits are zero and its length is 11.
- R7: If only data trace messages were discarded during the episode, the error code is 5'b00010.
- R8: If any watchpoint message was discarded during the episode, the error code is 5'b01000. This includes the arrival that started the overflow.
- R9: The record of discarded kinds is cleared when the error message is stored, so a later episode reports only its own losses.
- R10: Arrivals in the cycle that the error message is written are discarded and count toward its code. Arrivals are admitted again from the next cycle.
- R11: While `out_valid` is high and `out_ready` is low, the presented message stays stable.
- R12: If both producers arrive when exactly one entry is free, the watchpoint message is stored and the data trace message is discarded. This starts an overflow whose code is 5'b00010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_valid | input | 1 | Watchpoint message present |
| wp_msg | input | 64 | Watchpoint payload |
| wp_len | input | 7 | Watchpoint length in bits |
| dt_valid | input | 1 | Data trace message present |
| dt_msg | input | 64 | Data trace payload |
| dt_len | input | 7 | Data trace length in bits |
| out_valid | output | 1 | Head message available |
| out_ready | input | 1 | Consumer takes the head message |
| out_msg | output | 64 | Head payload |
| out_len | output | 7 | Head length in bits |

## Verification
The hardest situations to reach are the boundary cycles of an overflow episode. These are the arrival that meets exactly one free slot while both producers are active, a watchpoint that arrives only in the middle of the drain, and an arrival in the very cycle the error entry is written. The stimulus first fills the queue to a chosen level with the consumer stalled. It then fires the trigger arrival and drains with producers still active each cycle, with a watchpoint injected at a fixed point of the drain. Finally, it checks the empty cycle, the error entry and the first readmitted message in turn. Running a clean episode right after one that lost a watchpoint shows that the lost-kind record was cleared.

// File: rtl/trq_pkg.sv
package trq_pkg;
  parameter int TRQ_MSG_W = 64;
  parameter int TRQ_LEN_W = 7;

  localparam logic [4:0] CODE_DT_ONLY = 5'b00010;
  localparam logic [4:0] CODE_WP_LOST = 5'b01000;
  localparam int         ERR_LEN      = 11;

  typedef struct packed {
    logic [TRQ_MSG_W-1:0] msg;
    logic [TRQ_LEN_W-1:0] len;
  } trq_entry_t;
endpackage

// File: rtl/trq_rst_sync.sv
module trq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/trq_store.sv
module trq_store
  import trq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_ns,
  input  logic            a_en,
  input  trq_entry_t      a_ent,
  input  logic            b_en,
  input  trq_entry_t      b_ent,
  input  logic            pop,
  output trq_entry_t      head,
  output logic [CW-1:0]   count
);
  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) wrap_inc = '0;
    else                     wrap_inc = p + AW'(1);
  endfunction

  trq_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, wr_ptr_p1;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          ptr_en;

  assign wr_ptr_p1 = wrap_inc(wr_ptr_q);

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic       we_a, we_b, we;
      trq_entry_t wdata;
      assign we_a  = a_en && (wr_ptr_q == AW'(gi));
      assign we_b  = b_en && (wr_ptr_p1 == AW'(gi));
      assign we    = we_a || we_b;
      assign wdata = we_a ? a_ent : b_ent;
      always_ff @(posedge clk) begin
        if (we) mem_q[gi] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    if (a_en && b_en) wr_ptr_d = wrap_inc(wr_ptr_p1);
    else if (a_en)    wr_ptr_d = wr_ptr_p1;
    rd_ptr_d = pop ? wrap_inc(rd_ptr_q) : rd_ptr_q;
    count_d  = count_q + CW'(a_en) + CW'(b_en) - CW'(pop);
    ptr_en   = a_en || b_en || pop;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  assign head  = mem_q[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/trq_admit.sv
module trq_admit #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          draining,
  input  logic [CW-1:0] count,
  input  logic          wp_valid,
  input  logic          dt_valid,
  output logic          take_wp,
  output logic          take_dt,
  output logic          drop_wp,
  output logic          drop_dt
);
  logic [CW-1:0] space;
  logic [CW-1:0] dt_need;

  always_comb begin
    space   = CW'(DEPTH) - count;
    dt_need = wp_valid ? CW'(2) : CW'(1);
    take_wp = !draining && wp_valid && (space >= CW'(1));
    take_dt = !draining && dt_valid && (space >= dt_need);
    drop_wp = wp_valid && !take_wp;
    drop_dt = dt_valid && !take_dt;
  end
endmodule

// File: rtl/trq_ovf_ctrl.sv
module trq_ovf_ctrl
  import trq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ns,
  input  logic       empty,
  input  logic       drop_wp,
  input  logic       drop_dt,
  output logic       draining,
  output logic       ins_err,
  output logic [4:0] err_code
);
  logic drain_q, drain_d;
  logic wp_lost_q, wp_lost_d;
  logic dt_lost_q, dt_lost_d;
  logic st_en;

  always_comb begin
    drain_d   = drain_q;
    wp_lost_d = wp_lost_q;
    dt_lost_d = dt_lost_q;
    if (!drain_q) begin
      if (drop_wp || drop_dt) begin
        drain_d   = 1'b1;
        wp_lost_d = drop_wp;
        dt_lost_d = drop_dt;
      end
    end else if (empty) begin
      drain_d   = 1'b0;
      wp_lost_d = 1'b0;
      dt_lost_d = 1'b0;
    end else begin
      wp_lost_d = wp_lost_q || drop_wp;
      dt_lost_d = dt_lost_q || drop_dt;
    end
    st_en    = (drain_d != drain_q) || (wp_lost_d != wp_lost_q) ||
               (dt_lost_d != dt_lost_q);
    ins_err  = drain_q && empty;
    err_code = (wp_lost_q || drop_wp) ? CODE_WP_LOST : CODE_DT_ONLY;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      drain_q   <= 1'b0;
      wp_lost_q <= 1'b0;
      dt_lost_q <= 1'b0;
    end else if (st_en) begin
      drain_q   <= drain_d;
      wp_lost_q <= wp_lost_d;
      dt_lost_q <= dt_lost_d;
    end
  end

  assign draining = drain_q;
endmodule

// File: rtl/trq_queue.sv
module trq_queue
  import trq_pkg::*;
#(
  parameter int         DEPTH    = 8,
  parameter logic [5:0] ERR_TYPE = 6'h08,
  localparam int        CW       = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wp_valid,
  input  logic [TRQ_MSG_W-1:0] wp_msg,
  input  logic [TRQ_LEN_W-1:0] wp_len,
  input  logic                 dt_valid,
  input  logic [TRQ_MSG_W-1:0] dt_msg,
  input  logic [TRQ_LEN_W-1:0] dt_len,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [TRQ_MSG_W-1:0] out_msg,
  output logic [TRQ_LEN_W-1:0] out_len
);
  logic          rst_ns;
  logic [CW-1:0] count;
  logic          draining, ins_err;
  logic [4:0]    err_code;
  logic          take_wp, take_dt, drop_wp, drop_dt;
  logic          a_en, b_en, pop;
  trq_entry_t    a_ent, b_ent, head;
  trq_entry_t    wp_ent, dt_ent, err_ent;

  trq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  trq_admit #(.DEPTH(DEPTH)) u_admit (
    .draining(draining), .count(count),
    .wp_valid(wp_valid), .dt_valid(dt_valid),
    .take_wp(take_wp), .take_dt(take_dt),
    .drop_wp(drop_wp), .drop_dt(drop_dt)
  );

  trq_ovf_ctrl u_ovf (
    .clk(clk), .rst_ns(rst_ns), .empty(count == '0),
    .drop_wp(drop_wp), .drop_dt(drop_dt),
    .draining(draining), .ins_err(ins_err), .err_code(err_code)
  );

  always_comb begin
    wp_ent.msg  = wp_msg;
    wp_ent.len  = wp_len;
    dt_ent.msg  = dt_msg;
    dt_ent.len  = dt_len;
    err_ent.msg = TRQ_MSG_W'({err_code, ERR_TYPE});
    err_ent.len = TRQ_LEN_W'(ERR_LEN);
    a_en  = 1'b0;
    b_en  = 1'b0;
    a_ent = wp_ent;
    b_ent = dt_ent;
    if (ins_err) begin
      a_en  = 1'b1;
      a_ent = err_ent;
    end else if (take_wp) begin
      a_en = 1'b1;
      b_en = take_dt;
    end else if (take_dt) begin
      a_en  = 1'b1;
      a_ent = dt_ent;
    end
    out_valid = (count != '0);
    pop       = out_valid && out_ready;
    out_msg   = head.msg;
    out_len   = head.len;
  end

  trq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_ns(rst_ns),
    .a_en(a_en), .a_ent(a_ent), .b_en(b_en), .b_ent(b_ent),
    .pop(pop), .head(head), .count(count)
  );
endmodule

// File: rtl/trq_queue_chk.sv
module trq_queue_chk
  import trq_pkg::*;
#(
  parameter int  DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_ns,
  input logic [CW-1:0]        count,
  input logic                 draining,
  input logic                 wp_valid,
  input logic                 take_wp,
  input logic                 take_dt,
  input logic                 drop_wp,
  input logic                 drop_dt,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [TRQ_MSG_W-1:0] out_msg,
  input logic [TRQ_LEN_W-1:0] out_len
);
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    count <= CW'(DEPTH));

  p_enter_drain_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (!draining && (drop_wp || drop_dt)) |=> draining);

  p_drain_blocks_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    draining |-> (!take_wp && !take_dt));

  p_err_insert_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (draining && count == '0) |=> (!draining && out_valid));

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (wp_valid && take_dt) |-> take_wp);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_msg) && $stable(out_len)));
endmodule

bind trq_queue trq_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .count(count), .draining(draining),
  .wp_valid(wp_valid), .take_wp(take_wp), .take_dt(take_dt),
  .drop_wp(drop_wp), .drop_dt(drop_dt), .out_valid(out_valid),
  .out_ready(out_ready), .out_msg(out_msg), .out_len(out_len)
);

// File: tb/trq_queue_tb.sv
module trq_queue_tb;
  localparam int DEPTH = 8;

  logic        clk;
  logic        rst_n;
  logic        wp_valid, dt_valid, out_ready, out_valid;
  logic [63:0] wp_msg, dt_msg, out_msg;
  logic [6:0]  wp_len, dt_len, out_len;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic        s_v;
  logic [63:0] s_msg;
  logic [6:0]  s_len;

  trq_queue u_dut (
    .clk(clk), .rst_n(rst_n),
    .wp_valid(wp_valid), .wp_msg(wp_msg), .wp_len(wp_len),
    .dt_valid(dt_valid), .dt_msg(dt_msg), .dt_len(dt_len),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_msg(out_msg), .out_len(out_len)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Row fields: {wp, dt, ready, exp_valid, exp_payload[7:0]}
  localparam logic [11:0] VEC [0:10] = '{
    {4'b0000, 8'h00}, {4'b1100, 8'h00}, {4'b0101, 8'hA1},
    {4'b0011, 8'hA1}, {4'b1011, 8'hD1}, {4'b0011, 8'hD2},
    {4'b1111, 8'hA4}, {4'b0001, 8'hA6}, {4'b0011, 8'hA6},
    {4'b0011, 8'hD6}, {4'b0000, 8'h00}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit wv, input bit dv, input bit rdy,
                     input logic [7:0] wpay, input logic [7:0] dpay);
    @(negedge clk);
    wp_valid  = wv;  wp_msg = {56'h0, wpay}; wp_len = 7'd16;
    dt_valid  = dv;  dt_msg = {56'h0, dpay}; dt_len = 7'd32;
    out_ready = rdy;
    #1;
    s_v = out_valid; s_msg = out_msg; s_len = out_len;
  endtask

  task automatic expect_msg(input logic [7:0] pay, input logic [6:0] len,
                            input string req);
    check(s_v == 1'b1, req, "valid", 64'(s_v), 64'h1);
    check(s_msg == {56'h0, pay}, req, "payload", s_msg, {56'h0, pay});
    check(s_len == len, req, "length", 64'(s_len), 64'(len));
  endtask

  task automatic ovf_case(input int fill, input bit tw, input bit td,
                          input bit mid_wp, input logic [4:0] code,
                          input string req);
    int nstore;
    logic [63:0] err;
    nstore = fill + ((fill < DEPTH && tw) ? 1 : 0);
    for (int i = 0; i < fill; i++) cyc(0, 1, 0, 8'h00, 8'h40 + 8'(i));
    cyc(tw, td, 0, 8'h70, 8'h50);
    for (int i = 0; i < nstore; i++) begin
      cyc(mid_wp && i == 2, 1, 1, 8'h7E, 8'hEE);
      if (i < fill) expect_msg(8'h40 + 8'(i), 7'd32, "R2 R4 R5");
      else          expect_msg(8'h70, 7'd16, "R12 R3");
    end
    cyc(0, 1, 1, 8'h00, 8'hEE);
    check(s_v == 1'b0, "R5", "empty before error", 64'(s_v), 64'h0);
    cyc(0, 1, 0, 8'h00, 8'hE1);
    err = (64'(code) << 6) | 64'h08;
    check(s_v && s_msg == err && s_len == 7'd11, req, "error entry", s_msg, err);
    cyc(0, 0, 1, 8'h00, 8'h00);
    check(s_v && s_msg == err, "R11", "error held", s_msg, err);
    cyc(0, 0, 1, 8'h00, 8'h00);
    expect_msg(8'hE1, 7'd32, "R10");
    cyc(0, 0, 0, 8'h00, 8'h00);
    check(s_v == 1'b0, "R10", "drained", 64'(s_v), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wp_valid = 0; dt_valid = 0; out_ready = 0;
    wp_msg = '0; dt_msg = '0; wp_len = '0; dt_len = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "valid after reset", 64'(out_valid), 64'h0);

    for (int r = 0; r < 11; r++) begin
      logic [11:0] v;
      v = VEC[r];
      cyc(v[11], v[10], v[9], 8'hA0 + 8'(r), 8'hD0 + 8'(r));
      if (v[8]) expect_msg(v[7:0], (v[7:4] == 4'hA) ? 7'd16 : 7'd32, "R2 R3 R11");
      else check(s_v == 1'b0, "R2", "valid low", 64'(s_v), 64'h0);
    end

    ovf_case(8, 0, 1, 0, 5'b00010, "R7");
    ovf_case(7, 1, 1, 0, 5'b00010, "R12");
    ovf_case(8, 1, 0, 0, 5'b01000, "R8");
    ovf_case(8, 0, 1, 1, 5'b01000, "R8");
    ovf_case(8, 0, 1, 0, 5'b00010, "R9");

    @(negedge clk) rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", "valid in reset", 64'(out_valid), 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule